// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank SDRAM and drives its command pins. After reset it brings the memory up in a fixed order. First it holds the memory in NOP for a stable wait, with clock enable and the data mask high. It then closes both banks with a single precharge and issues a set number of auto refresh commands, each one followed by the refresh recovery time. Last, it loads the mode register and waits out the lockout that follows the load.

When bring-up is complete the block raises `ready`. From then on it generates refresh demand at a fixed interval. That interval comes from the clock frequency and the array budget of 2048 refreshes per 32 ms, rounded down so the budget is never exceeded. The user side acknowledges demand by driving `ref_gnt` high once both banks are idle, and only then is an auto refresh issued. Demand that cannot be served at once is counted and served later, up to a limit.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is held and during the first WAIT_CYC cycles after its release (WAIT_CYC = CLK_KHZ*WAIT_US/1000), the command is NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `cke` is high, `dqm` is high and `ready` is low.
- R2: In cycle WAIT_CYC after reset release, a precharge command (4'b0010) is issued with `addr[10]` high, which closes both banks.
- R3: The first auto refresh (4'b0001, `cke` high) comes exactly T_RP cycles after the precharge.
- R4: INIT_REFS auto refresh commands are issued during bring-up. Consecutive ones are spaced exactly T_RFC cycles apart, with only NOP between them.
- R5: The mode register set (4'b0000) comes T_RFC cycles after the last bring-up refresh. It carries MODE_WORD on `addr` and zero on `ba`.
- R6: `ready` rises exactly T_MRD cycles after the mode register set and stays high until reset. `dqm` is low whenever `ready` is high.
- R7: The refresh interval is REF_INT = floor(CLK_KHZ*REF_PERIOD_US/1000/REF_COUNT) cycles. `ref_req` first rises REF_INT+1 cycles after the mode register set, and new demand arrives every REF_INT cycles after that.
- R8: A periodic auto refresh is issued only in the cycle after an edge at which `ref_gnt` was high. If `ref_req` is high and `ref_gnt` is high, the refresh comes in the next cycle.
- R9: Unserved demand accumulates up to MAX_OWED and then saturates. Once granted, the owed refreshes are issued back to back, spaced T_RFC apart. `ref_req` falls when the debt reaches zero.
- R10: Bring-up does not depend on `ref_gnt`, and `ref_req` stays low until `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | User side reports both banks idle and grants a refresh |
| ref_req | output | 1 | Refresh demand is pending |
| ready | output | 1 | Bring-up complete; memory usable |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | 1 | Data mask, high during bring-up |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus; bit 10 selects all banks on precharge |

## Verification
A wrong state in the sequencer shows up as a command in the wrong cycle: a precharge, refresh or mode load that arrives early, late, twice or never. The bench compares every cycle of bring-up against a table of expected command positions, so such an error is reported within the cycle it occurs. A faulty interval timer or debt counter shows up as a `ref_req` edge that is off by one or more cycles, or as the wrong number of refreshes after a long grant hold-off. Both of these are visible within one refresh interval.

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh #(
  parameter int ADDR_W        = 11,
  parameter int BA_W          = 1,
  parameter int CLK_KHZ       = 100000,
  parameter int WAIT_US       = 200,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 7,
  parameter int T_MRD         = 2,
  parameter int INIT_REFS     = 2,
  parameter int REF_PERIOD_US = 32000,
  parameter int REF_COUNT     = 2048,
  parameter int MAX_OWED      = 8,
  parameter logic [ADDR_W-1:0] MODE_WORD = 11'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ready,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dqm,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int WAIT_CYC = int'((longint'(CLK_KHZ) * longint'(WAIT_US)) / 64'd1000);
  localparam int REF_INT  = int'((longint'(CLK_KHZ) * longint'(REF_PERIOD_US)) / 64'd1000 / longint'(REF_COUNT));
  localparam int MAXT     = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                           : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int MAXC     = (WAIT_CYC > MAXT) ? WAIT_CYC : MAXT;
  localparam int CNT_W    = $clog2(MAXC + 1);
  localparam int TW       = $clog2(REF_INT + 1);
  localparam int OW       = $clog2(MAX_OWED + 1);
  localparam int IW       = $clog2(INIT_REFS + 1);

  localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LD   = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] RFC_LD  = CNT_W'(T_RFC - 2);
  localparam logic [CNT_W-1:0] MRD_LD  = CNT_W'(T_MRD - 2);
  localparam logic [TW-1:0]    INT_LD  = TW'(REF_INT - 1);
  localparam logic [OW-1:0]    OWED_MX = OW'(MAX_OWED);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [3:0] {
    S_WAIT, S_PRE, S_PRE_GAP, S_IREF, S_IREF_GAP,
    S_MRS, S_MRS_GAP, S_IDLE, S_REF, S_REF_GAP
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [IW-1:0]    nref;
  logic [TW-1:0]    tcnt;
  logic [OW-1:0]    owed;
  logic             rdy;
  logic             run, tick, go_ref;

  assign run     = st inside {S_MRS_GAP, S_IDLE, S_REF, S_REF_GAP};
  assign tick    = run && (tcnt == '0);
  assign go_ref  = (owed != '0) && ref_gnt;
  assign ref_req = (owed != '0);
  assign ready   = rdy;
  assign dqm     = ~rdy;
  assign cke     = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      cnt  <= WAIT_LD;
      nref <= '0;
      rdy  <= 1'b0;
    end else begin
      case (st)
        S_WAIT:     if (cnt == '0) st <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE:      begin st <= S_PRE_GAP; cnt <= RP_LD; end
        S_PRE_GAP:  if (cnt == '0) st <= S_IREF; else cnt <= cnt - 1'b1;
        S_IREF:     begin st <= S_IREF_GAP; cnt <= RFC_LD; nref <= nref + 1'b1; end
        S_IREF_GAP: if (cnt == '0) st <= (nref == IW'(INIT_REFS)) ? S_MRS : S_IREF;
                    else cnt <= cnt - 1'b1;
        S_MRS:      begin st <= S_MRS_GAP; cnt <= MRD_LD; end
        S_MRS_GAP:  if (cnt == '0) begin st <= S_IDLE; rdy <= 1'b1; end
                    else cnt <= cnt - 1'b1;
        S_IDLE:     if (go_ref) st <= S_REF;
        S_REF:      begin st <= S_REF_GAP; cnt <= RFC_LD; end
        S_REF_GAP:  if (cnt == '0) st <= go_ref ? S_REF : S_IDLE;
                    else cnt <= cnt - 1'b1;
        default:    st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= INT_LD;
      owed <= '0;
    end else begin
      if (st == S_MRS || tick) tcnt <= INT_LD;
      else if (run)            tcnt <= tcnt - 1'b1;
      case ({tick, st == S_REF})
        2'b10:   if (owed != OWED_MX) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    ba   = '0;
    addr = '0;
    case (st)
      S_PRE:         begin {cs_n, ras_n, cas_n, we_n} = C_PRE; addr[10] = 1'b1; end
      S_IREF, S_REF: {cs_n, ras_n, cas_n, we_n} = C_REF;
      S_MRS:         begin {cs_n, ras_n, cas_n, we_n} = C_MRS; addr = MODE_WORD; end
      default:       ;
    endcase
  end

  logic [3:0]       cmd, last_cmd;
  logic [CNT_W-1:0] since;
  logic             is_cmd;
  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_cmd = (cmd != C_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= '0;
      last_cmd <= C_NOP;
    end else if (is_cmd) begin
      since    <= CNT_W'(1);
      last_cmd <= cmd;
    end else if (since != '1) begin
      since    <= since + 1'b1;
    end
  end

  p_wait_before_pre_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last_cmd == C_NOP) |-> (since >= CNT_W'(WAIT_CYC)));
  p_pre_all_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> addr[10]);
  p_trp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last_cmd == C_PRE) |-> (since >= CNT_W'(T_RP)));
  p_trfc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last_cmd == C_REF) |-> (since >= CNT_W'(T_RFC)));
  p_tmrd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last_cmd == C_MRS) |-> (since >= CNT_W'(T_MRD)));
  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_gnt_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd == C_REF) |-> $past(ref_gnt));
  p_owed_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OWED_MX);
  p_no_req_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !ref_req);

endmodule

// File: tb/sdram_boot_refresh_tb_top.sv
module sdram_boot_refresh_tb_top;
  localparam int CLK_P     = 10;
  localparam int WAIT_CYC  = 20;
  localparam int T_RP      = 3;
  localparam int T_RFC     = 5;
  localparam int T_MRD     = 2;
  localparam int REF_INT   = 32000 / 2048;
  localparam int MAX_OWED  = 3;
  localparam logic [10:0] MODE = 11'h032;

  localparam int C_PRE = WAIT_CYC;
  localparam int C_R1  = C_PRE + T_RP;
  localparam int C_R2  = C_R1 + T_RFC;
  localparam int C_MRS = C_R2 + T_RFC;
  localparam int C_RDY = C_MRS + T_MRD;
  localparam int C_REQ = C_MRS + REF_INT + 1;
  localparam int T2    = C_REQ + MAX_OWED * REF_INT;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  localparam logic [19:0] EXP [7] = '{
    {16'(C_PRE), PRE}, {16'(C_R1), REF}, {16'(C_R2), REF}, {16'(C_MRS), MRS},
    {16'(C_REQ + 1), REF}, {16'(C_REQ + 1 + REF_INT), REF}, {16'(C_REQ + 1 + 2 * REF_INT), REF}
  };

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ready, cke, cs_n, ras_n, cas_n, we_n, dqm;
  logic [0:0]  ba;
  logic [10:0] addr;
  logic [3:0]  cmd;
  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 0;

  assign cmd = {cs_n, ras_n, cas_n, we_n};
  always #(CLK_P / 2) clk = ~clk;

  sdram_boot_refresh #(
    .CLK_KHZ(1000), .WAIT_US(20), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .INIT_REFS(2), .REF_PERIOD_US(32000), .REF_COUNT(2048), .MAX_OWED(MAX_OWED),
    .MODE_WORD(MODE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dqm(dqm),
    .ba(ba), .addr(addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic start(input logic gnt);
    @(negedge clk);
    rst_n = 1'b0;
    ref_gnt = gnt;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset cmd", cmd, NOP);
    chk("R1 reset dqm", dqm, 1);
    chk("R1 reset ready", ready, 0);
    chk("R1 reset ref_req", ref_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    start(1'b1);
    chk("R1 cke", cke, 1);
    for (int i = 0; i < 7; i++) begin
      int stray = 0;
      int bad_dqm = 0;
      while (cyc < int'(EXP[i][19:4])) begin
        if (cmd != NOP) stray++;
        if (cyc < WAIT_CYC && (dqm != 1'b1 || cke != 1'b1)) bad_dqm++;
        if (cyc == C_RDY - 1) chk("R6 ready low before lockout", ready, 0);
        if (cyc == C_RDY) begin
          chk("R6 ready rise", ready, 1);
          chk("R6 dqm low when ready", dqm, 0);
        end
        if (cyc == C_REQ - 1) chk("R7 ref_req before interval", ref_req, 0);
        if (cyc == C_REQ) chk("R7 ref_req rise", ref_req, 1);
        step();
      end
      chk("R1 R4 only NOP between commands", stray, 0);
      if (i == 0) chk("R1 dqm and cke high in wait", bad_dqm, 0);
      chk(i == 0 ? "R2 precharge" : i == 3 ? "R5 mode set" : i < 3 ? "R3 R4 init refresh" : "R8 granted refresh",
          cmd, EXP[i][3:0]);
      if (i == 0) chk("R2 addr10", addr[10], 1);
      if (i == 3) begin
        chk("R5 mode word", addr, MODE);
        chk("R5 bank zero", ba, 0);
      end
      step();
    end

    start(1'b0);
    begin
      int mrs_at = -1;
      int late_ref = 0;
      int req_early = 0;
      int nref = 0;
      while (cyc < T2) begin
        if (cmd == MRS) mrs_at = cyc;
        if (cmd == REF && cyc > C_MRS) late_ref++;
        if (!ready && ref_req) req_early++;
        step();
      end
      chk("R10 bring-up without grant", mrs_at, C_MRS);
      chk("R10 no request before ready", req_early, 0);
      chk("R8 no refresh without grant", late_ref, 0);
      chk("R9 request held while owed", ref_req, 1);
      ref_gnt = 1'b1;
      step();
      chk("R8 refresh right after grant", cmd, REF);
      while (cyc < T2 + REF_INT) begin
        if (cmd == REF) nref++;
        if (cyc == T2 + 1 + (MAX_OWED - 1) * T_RFC + 2) chk("R9 request drops at zero debt", ref_req, 0);
        if (cyc == T2 + 1 + T_RFC) chk("R9 owed refresh spaced tRFC", cmd, REF);
        step();
      end
      chk("R9 saturated debt count", nref, MAX_OWED);
      chk("R6 ready still high", ready, 1);
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-run cmd", cmd, NOP);
    chk("R1 reset mid-run ready", ready, 0);
    chk("R1 reset mid-run dqm", dqm, 1);

    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule